// File: doc/BRIEF.md
# Flash Fetch Cache with Prefetch

This block sits between the code-fetch port of an 8-bit processor and a flash array that is read one 32-bit word at a time. It keeps two single-line caches of four bytes each, both aligned to a 4-byte boundary. One line serves instruction fetches and the other serves constant-data reads, so the two kinds of traffic never evict each other. Whenever any byte of a line is missed, the whole aligned word is loaded. An optional look-ahead buffer reads the next sequential instruction line while the processor is still working through the current one.

A 2-bit operating mode sets how the block behaves. It can turn caching off, so that every read goes to flash. It can cache normally. It can cache and also read ahead. Or it can run in a fixed-latency mode, where every access takes the same number of cycles whether it hits or misses. Writing the mode, or pulsing the flash-modified strobe, discards every cached line and any look-ahead result still in flight. The flash port carries one read at a time. A demand miss takes precedence over starting a look-ahead read. A look-ahead read already in flight is always allowed to finish before a demand read is issued.

Top module: `fetch_cache`

## Requirements
- R1: A miss on any byte loads the whole aligned 4-byte line with one flash read. Flash word address = byte address with its two low bits dropped. Byte k of the line sits at bits 8k+7:8k of the returned word. The other three bytes then hit with no further flash read.
- R2: An instruction read (cpu_data_i=0) and a constant read (cpu_data_i=1) use separate lines. A constant-read miss leaves the cached instruction line in place, and the reverse also holds.
- R3: In mode 00 (disabled), every read issues one flash read and takes FLASH_LAT+1 cycles, and no line is kept.
- R4: In mode 01 (normal), a hit returns ready one cycle after the request and a miss returns it FLASH_LAT+1 cycles after. Ready is a one-cycle pulse, given only to a pending request.
- R5: In mode 10 (prefetch), a valid instruction line at line address T triggers a look-ahead read of line T+1 whenever the flash port is free. An instruction read that hits the look-ahead buffer returns in one cycle, moves the buffer into the instruction line, and starts a look-ahead read of the line after it.
- R6: In mode 11 (real-time), every access takes exactly FLASH_LAT+1 cycles. A hit is served from its line with no flash read.
- R7: A mode write (mode_wr_i) or a flash-modified pulse (flash_mod_i) invalidates both lines and the look-ahead buffer, and the result of any read then in flight is not stored.
- R8: At most one flash read is outstanding. A demand miss that arrives while a look-ahead read is in flight waits for that read's return before it issues its own request.
- R9: After reset, all lines are invalid, no flash read is issued, and the mode is 01 (normal caching without look-ahead).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | 1 | Load mode_i into the mode register and flush |
| mode_i | input | 2 | New mode: 00 off, 01 normal, 10 prefetch, 11 real-time |
| flash_mod_i | input | 1 | Flash contents changed; flush all lines |
| cpu_req_i | input | 1 | Read request, held until ready |
| cpu_data_i | input | 1 | 1 = constant-data read, 0 = instruction fetch |
| cpu_addr_i | input | AW | Byte address of the read |
| cpu_ready_o | output | 1 | One-cycle pulse: read data is valid |
| cpu_rdata_o | output | 8 | Read byte |
| fl_req_o | output | 1 | One-cycle flash word read request |
| fl_addr_o | output | AW-2 | Flash word address |
| fl_valid_i | input | 1 | Flash read data valid |
| fl_rdata_i | input | 32 | Flash read word |

## Verification
The assertions assume that flash returns exactly one data-valid pulse for each request, FLASH_LAT cycles after it. They also assume that the processor holds its request and address steady until it sees ready. The bench's flash model is a fixed-length delay line, so it always meets the first assumption. Every read goes through a single task that holds the request until ready and drops it for one cycle afterwards, so it meets the second. Mode writes and flash-modified pulses are only issued between reads, and the bench then waits out any look-ahead read that was in flight. This keeps the fixed-latency and demand-ordering checks free of leftover flash traffic.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DWAIT = 2'd1,
        ST_HOLD  = 2'd2
    } fc_state_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_NORM = 2'b01,
        MD_PF   = 2'b10,
        MD_RT   = 2'b11
    } fc_mode_e;
endpackage

// File: rtl/fc_byte_sel.sv
module fc_byte_sel #(
    parameter int WB = 4
) (
    input  logic [WB*8-1:0]       word_i,
    input  logic [$clog2(WB)-1:0] sel_i,
    output logic [7:0]            byte_o
);
    always_comb byte_o = word_i[{sel_i, 3'b000} +: 8];
endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
    import fc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int FLASH_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr_i,
    input  logic [1:0]    mode_i,
    input  logic          flash_mod_i,
    input  logic          cpu_req_i,
    input  logic          cpu_data_i,
    input  logic [AW-1:0] cpu_addr_i,
    output logic          cpu_ready_o,
    output logic [7:0]    cpu_rdata_o,
    output logic          fl_req_o,
    output logic [AW-3:0] fl_addr_o,
    input  logic          fl_valid_i,
    input  logic [31:0]   fl_rdata_i
);
    localparam int WB   = 4;
    localparam int OFFW = $clog2(WB);
    localparam int TAGW = AW - OFFW;
    localparam int CW   = $clog2(FLASH_LAT + 1);
    localparam int NSRC = 4;  // instr line, data line, look-ahead, flash return

    typedef struct packed {
        logic            v;
        logic [TAGW-1:0] tag;
        logic [31:0]     dat;
    } line_t;

    typedef struct packed {
        fc_state_e       st;
        fc_mode_e        mode;
        line_t           il;
        line_t           dl;
        line_t           pb;
        logic            pf_busy;
        logic [TAGW-1:0] pf_tag;
        logic            stale;
        logic [TAGW-1:0] rq_tag;
        logic [OFFW-1:0] rq_off;
        logic            rq_data;
        logic [CW-1:0]   cnt;
        logic            rdy;
        logic [7:0]      rdata;
    } regs_t;

    regs_t q, d;

    logic [TAGW-1:0] req_tag;
    logic [OFFW-1:0] req_off;
    assign req_tag = cpu_addr_i[AW-1:OFFW];
    assign req_off = cpu_addr_i[OFFW-1:0];

    // byte selection for every data source
    logic [31:0]     src_word [NSRC];
    logic [OFFW-1:0] src_sel  [NSRC];
    logic [7:0]      src_byte [NSRC];
    assign src_word[0] = q.il.dat;   assign src_sel[0] = req_off;
    assign src_word[1] = q.dl.dat;   assign src_sel[1] = req_off;
    assign src_word[2] = q.pb.dat;   assign src_sel[2] = req_off;
    assign src_word[3] = fl_rdata_i; assign src_sel[3] = q.rq_off;

    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        fc_byte_sel #(.WB(WB)) u_sel (
            .word_i (src_word[g]),
            .sel_i  (src_sel[g]),
            .byte_o (src_byte[g])
        );
    end

    logic flush, accept, cached, flash_free, il_hit, dl_hit, pb_hit;
    logic hit, promote, demand, base_v;
    logic [TAGW-1:0] base_tag, next_tag;
    logic [7:0] hit_byte;

    always_comb begin
        d        = q;
        d.rdy    = 1'b0;
        fl_req_o = 1'b0;
        fl_addr_o = '0;
        demand   = 1'b0;
        hit      = 1'b0;
        promote  = 1'b0;
        hit_byte = '0;

        flush      = mode_wr_i | flash_mod_i;
        accept     = cpu_req_i && !q.rdy && (q.st == ST_IDLE);
        cached     = (q.mode != MD_OFF);
        flash_free = (q.st != ST_DWAIT) && !q.pf_busy;
        il_hit     = q.il.v && (q.il.tag == req_tag);
        dl_hit     = q.dl.v && (q.dl.tag == req_tag);
        pb_hit     = q.pb.v && (q.pb.tag == req_tag) && (q.mode == MD_PF);

        // look-ahead return
        if (fl_valid_i && q.pf_busy) begin
            d.pf_busy = 1'b0;
            d.stale   = 1'b0;
            if (!q.stale) d.pb = '{v: 1'b1, tag: q.pf_tag, dat: fl_rdata_i};
        end

        case (q.st)
            ST_DWAIT: if (fl_valid_i) begin
                d.st    = ST_IDLE;
                d.rdy   = 1'b1;
                d.rdata = src_byte[3];
                d.stale = 1'b0;
                if (!q.stale && cached) begin
                    if (q.rq_data) d.dl = '{v: 1'b1, tag: q.rq_tag, dat: fl_rdata_i};
                    else           d.il = '{v: 1'b1, tag: q.rq_tag, dat: fl_rdata_i};
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    d.st  = ST_IDLE;
                    d.rdy = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: if (accept) begin
                if (cpu_data_i) begin
                    hit      = cached && dl_hit;
                    hit_byte = src_byte[1];
                end else begin
                    hit      = cached && (il_hit || pb_hit);
                    promote  = !il_hit && pb_hit;
                    hit_byte = il_hit ? src_byte[0] : src_byte[2];
                end
                if (hit) begin
                    d.rdata = hit_byte;
                    if (q.mode == MD_RT) begin
                        d.st  = ST_HOLD;
                        d.cnt = CW'(FLASH_LAT - 1);
                    end else begin
                        d.rdy = 1'b1;
                    end
                    if (promote) begin
                        d.il   = q.pb;
                        d.pb.v = 1'b0;
                    end
                end else if (flash_free) begin
                    demand    = 1'b1;
                    fl_req_o  = 1'b1;
                    fl_addr_o = req_tag;
                    d.st      = ST_DWAIT;
                    d.rq_tag  = req_tag;
                    d.rq_off  = req_off;
                    d.rq_data = cpu_data_i;
                end
            end
        endcase

        // sequential look-ahead, lower priority than demand
        base_v   = promote ? 1'b1 : q.il.v;
        base_tag = promote ? q.pb.tag : q.il.tag;
        next_tag = base_tag + 1'b1;
        if ((q.mode == MD_PF) && !demand && flash_free && !flush && base_v &&
            !(d.pb.v && d.pb.tag == next_tag)) begin
            fl_req_o  = 1'b1;
            fl_addr_o = next_tag;
            d.pf_busy = 1'b1;
            d.pf_tag  = next_tag;
            d.pb.v    = 1'b0;
        end

        if (flush) begin
            d.il.v  = 1'b0;
            d.dl.v  = 1'b0;
            d.pb.v  = 1'b0;
            d.stale = d.pf_busy || (d.st == ST_DWAIT);
            if (mode_wr_i) d.mode = fc_mode_e'(mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= MD_NORM;
        end else begin
            q <= d;
        end
    end

    assign cpu_ready_o = q.rdy;
    assign cpu_rdata_o = q.rdata;

    // outstanding flash reads, tracked from the port pins
    logic [1:0] outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outst_q <= '0;
        else case ({fl_req_o, fl_valid_i})
            2'b10:   outst_q <= outst_q + 1'b1;
            2'b01:   outst_q <= outst_q - 1'b1;
            default: outst_q <= outst_q;
        endcase
    end

    // R8
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req_o |-> (outst_q == 2'd0));
    // R4
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |=> !cpu_ready_o);
    // R4
    ready_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready_o |-> $past(cpu_req_i));
    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_i || flash_mod_i) |=> !(q.il.v || q.dl.v || q.pb.v));
    // R3
    off_keeps_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MD_OFF) |-> !(q.il.v || q.dl.v || q.pb.v));
endmodule

// File: tb/fetch_cache_test.sv
module fetch_cache_test;
    localparam int AW  = 16;
    localparam int LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_wr = 1'b0, flash_mod = 1'b0, cpu_req = 1'b0, cpu_data = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, fl_req, fl_valid;
    logic [7:0]    cpu_rdata;
    logic [AW-3:0] fl_addr;
    logic [31:0]   fl_rdata;

    int checks = 0, errors = 0, nreads = 0;

    always #2 clk = ~clk;

    fetch_cache #(.AW(AW), .FLASH_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_i(mode),
        .flash_mod_i(flash_mod), .cpu_req_i(cpu_req), .cpu_data_i(cpu_data),
        .cpu_addr_i(cpu_addr), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
        .fl_req_o(fl_req), .fl_addr_o(fl_addr), .fl_valid_i(fl_valid),
        .fl_rdata_i(fl_rdata)
    );

    function automatic logic [7:0] ref_byte(input logic [15:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd29;
        return t ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [31:0] ref_word(input logic [13:0] w);
        return {ref_byte({w, 2'd3}), ref_byte({w, 2'd2}),
                ref_byte({w, 2'd1}), ref_byte({w, 2'd0})};
    endfunction

    // flash model: fixed-latency delay line
    logic          pv [LAT];
    logic [AW-3:0] pa [LAT];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin pv[i] <= 1'b0; pa[i] <= '0; end
        end else begin
            for (int i = LAT - 1; i > 0; i--) begin pv[i] <= pv[i-1]; pa[i] <= pa[i-1]; end
            pv[0] <= fl_req;
            pa[0] <= fl_addr;
            if (fl_req) nreads++;
        end
    end
    assign fl_valid = pv[LAT-1];
    assign fl_rdata = ref_word(pa[LAT-1]);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, input logic isd, output int lat, output logic [7:0] dat);
        cpu_addr = a; cpu_data = isd; cpu_req = 1'b1; lat = 0;
        do begin @(posedge clk); #1; lat++; end while (!cpu_ready && lat < 100);
        dat = cpu_rdata;
        cpu_req = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m; mode_wr = 1'b1;
        @(posedge clk); #1;
        mode_wr = 1'b0;
        idle(LAT + 2);
    endtask

    task automatic pulse_mod();
        flash_mod = 1'b1;
        @(posedge clk); #1;
        flash_mod = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, n0;
        logic [7:0] dat;
        logic [15:0] a;
        logic isd, iv, dv;
        logic [13:0] it, dt;
        logic exp_hit;
        void'($urandom(32'd20240611));

        idle(3);
        rst_n = 1'b1;
        #1;
        // R9 reset state
        chk(!cpu_ready && !fl_req, "R9 idle after reset", int'(cpu_ready), 0);

        // R1 / R4 / R9: normal caching after reset, aligned line fill
        n0 = nreads;
        rd(16'h00F1, 1'b0, lat, dat);
        chk(lat == LAT + 1, "R4 miss latency", lat, LAT + 1);
        chk(dat == ref_byte(16'h00F1), "R1 miss data", dat, ref_byte(16'h00F1));
        for (int k = 0; k < 4; k++) begin
            rd(16'h00F0 + 16'(k), 1'b0, lat, dat);
            chk(lat == 1, "R1 line hit latency", lat, 1);
            chk(dat == ref_byte(16'h00F0 + 16'(k)), "R1 line hit data", dat, ref_byte(16'h00F0 + 16'(k)));
        end
        idle(LAT + 2);
        chk(nreads - n0 == 1, "R9 one read, no look-ahead in default mode", nreads - n0, 1);

        // R2: split lines
        rd(16'h0232, 1'b1, lat, dat);
        chk(lat == LAT + 1 && dat == ref_byte(16'h0232), "R2 data miss", lat, LAT + 1);
        rd(16'h00F2, 1'b0, lat, dat);
        chk(lat == 1 && dat == ref_byte(16'h00F2), "R2 instr line kept", lat, 1);
        rd(16'h0231, 1'b1, lat, dat);
        chk(lat == 1 && dat == ref_byte(16'h0231), "R2 data line hit", lat, 1);

        // R7: flash-modified pulse flushes
        pulse_mod();
        rd(16'h00F0, 1'b0, lat, dat);
        chk(lat == LAT + 1, "R7 miss after flash-modified", lat, LAT + 1);

        // R3: disabled
        set_mode(2'b00);
        for (int k = 0; k < 2; k++) begin
            n0 = nreads;
            rd(16'h00F0, 1'b0, lat, dat);
            chk(lat == LAT + 1 && nreads - n0 == 1, "R3 every read to flash", lat, LAT + 1);
        end

        // R5: look-ahead
        set_mode(2'b10);
        n0 = nreads;
        rd(16'h0100, 1'b0, lat, dat);
        idle(LAT + 2);
        chk(nreads - n0 == 2, "R5 look-ahead issued", nreads - n0, 2);
        rd(16'h0105, 1'b0, lat, dat);
        chk(lat == 1 && dat == ref_byte(16'h0105), "R5 look-ahead hit", lat, 1);
        idle(LAT + 2);
        chk(nreads - n0 == 3, "R5 next look-ahead after promotion", nreads - n0, 3);
        rd(16'h0108, 1'b0, lat, dat);
        chk(lat == 1 && dat == ref_byte(16'h0108), "R5 second look-ahead hit", lat, 1);

        // R8: demand waits for in-flight look-ahead
        set_mode(2'b10);
        rd(16'h0200, 1'b0, lat, dat);
        rd(16'h0300, 1'b1, lat, dat);
        chk(lat == 2 * LAT + 1, "R8 demand behind look-ahead", lat, 2 * LAT + 1);
        chk(dat == ref_byte(16'h0300), "R8 demand data", dat, ref_byte(16'h0300));
        rd(16'h0204, 1'b0, lat, dat);
        chk(lat == 1, "R8 completed look-ahead usable", lat, 1);

        // R7: in-flight look-ahead discarded by flush
        rd(16'h0400, 1'b0, lat, dat);
        pulse_mod();
        idle(LAT + 2);
        rd(16'h0404, 1'b0, lat, dat);
        chk(lat == LAT + 1 && dat == ref_byte(16'h0404), "R7 cancelled look-ahead", lat, LAT + 1);

        // R6: real-time
        set_mode(2'b11);
        rd(16'h0500, 1'b0, lat, dat);
        chk(lat == LAT + 1, "R6 miss latency", lat, LAT + 1);
        n0 = nreads;
        rd(16'h0501, 1'b0, lat, dat);
        chk(lat == LAT + 1 && nreads == n0, "R6 hit latency, no flash read", lat, LAT + 1);
        chk(dat == ref_byte(16'h0501), "R6 hit data", dat, ref_byte(16'h0501));

        // random traffic in every mode
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            iv = 1'b0; dv = 1'b0; it = '0; dt = '0;
            for (int k = 0; k < 40; k++) begin
                a   = 16'h0600 + 16'($urandom % 48);
                isd = 1'($urandom % 2);
                exp_hit = isd ? (dv && dt == a[15:2]) : (iv && it == a[15:2]);
                rd(a, isd, lat, dat);
                chk(dat == ref_byte(a), "R1 random data", dat, ref_byte(a));
                case (m)
                    0: chk(lat == LAT + 1, "R3 random latency", lat, LAT + 1);
                    1: chk(lat == (exp_hit ? 1 : LAT + 1), "R4 random latency", lat, exp_hit ? 1 : LAT + 1);
                    2: chk(lat >= 1 && lat <= 2 * LAT + 2, "R5 random latency bound", lat, 2 * LAT + 2);
                    default: chk(lat == LAT + 1, "R6 random latency", lat, LAT + 1);
                endcase
                if (isd) begin dv = 1'b1; dt = a[15:2]; end
                else     begin iv = 1'b1; it = a[15:2]; end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule